// File: doc/BRIEF.md
# CRC-16 Receive Checker with Release Buffer

This block checks a received byte stream for transmission errors with the 16-bit cyclic redundancy code used on USB data packets. One byte per clock enters the block and is written into a holding buffer. A byte-wide parallel CRC network folds the same byte into a 16-bit running register in that cycle. When the byte marked as last arrives, the block gives its verdict. It raises a one-cycle ok or error pulse, and then releases the held bytes in order with the verdict attached to each one.

The block offers two ways to judge a frame, and the mode is chosen per frame at its first byte. In compare mode the stream carries only payload. The one's complement of the final register is compared with a separately supplied 16-bit CRC. In residue mode the two CRC bytes follow the payload in the stream, and the frame is correct when the register ends at a fixed residue. A frame longer than the buffer always fails.

The control is a three-state machine. IDLE waits for a byte. A byte without the last flag moves it to RECV (transition "start"). A byte with the last flag moves it straight to DRAIN (transition "short frame"). RECV stays in RECV for each further byte and moves to DRAIN when the last byte is accepted (transition "end of frame"). DRAIN sends one held byte per cycle and returns to IDLE once the buffer is empty (transition "drained"). Input bytes that arrive while the block is in DRAIN are dropped.

Top module: `crc16_rx_checker`

## Requirements
- R1: The CRC uses polynomial x^16+x^15+x^2+1 in reflected form (0xA001), with data bits taken LSB first. The register is preset to 0xFFFF at the first byte of every frame, and one byte is folded in per accepted clock.
- R2: In compare mode (in_mode=0 at the first byte), a frame passes exactly when the bitwise inverse of the final register equals rx_crc as sampled with the last byte. The CRC of the ASCII string "123456789" is 0xB4C8.
- R3: In residue mode (in_mode=1 at the first byte), the stream carries the inverted CRC after the payload, low byte first. The frame passes exactly when the final register equals 0xB001. in_mode is ignored after the first byte.
- R4: In the cycle after the last byte is accepted, exactly one of ok_pulse and err_pulse is high, for that one cycle only. The two are never high together.
- R5: Starting the cycle after the verdict pulse, the stored bytes appear on out_data in arrival order, one per cycle with out_valid high. out_pass holds the frame's verdict (1 = pass) during the whole release.
- R6: At most DEPTH bytes of a frame are stored and released. A frame with more bytes than that drops the excess and gets an error verdict.
- R7: Bytes presented while the block is releasing (state DRAIN) are ignored. They produce no verdict and do not change the next frame's CRC or data.
- R8: After reset, ok_pulse, err_pulse, out_valid and out_pass are low, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A byte is present on in_data |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | The present byte ends the frame |
| in_mode | input | 1 | Judging mode, sampled at the first byte: 0 compare, 1 residue |
| rx_crc | input | 16 | Received CRC for compare mode, sampled with the last byte |
| ok_pulse | output | 1 | One-cycle pulse: frame passed |
| err_pulse | output | 1 | One-cycle pulse: frame failed |
| out_valid | output | 1 | A released byte is present on out_data |
| out_data | output | 8 | Released byte |
| out_pass | output | 1 | Verdict of the frame being released |

## Verification
The hardest situations to reach from the ports are a frame that runs past the buffer depth and bytes that arrive while the buffer is still draining. Neither occurs in a well-behaved stream. The bench builds frames up to a few bytes longer than DEPTH, both on purpose and at random. During some releases it drives random bytes with random last flags through every DRAIN cycle, and then checks that the next frame's verdict and data are unaffected. Random frames in both modes, with single-bit corruption of the data or the CRC, add to directed single-byte, exact-depth and known-string frames.

// File: rtl/crc16_rx_pkg.sv
package crc16_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RECV  = 2'd1,
        ST_DRAIN = 2'd2
    } rx_state_e;

    localparam logic [15:0] CRC_PRESET    = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;
    localparam logic [15:0] CRC_RESIDUE   = 16'hB001;

endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
    parameter int          DATA_W = 8,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'hA001
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [CRC_W-1:0]  crc_out
);

    // One stage per data bit, LSB first, reflected shift to the right.
    logic [CRC_W-1:0] stage [0:DATA_W];

    assign stage[0] = crc_in;

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic fb;
        assign fb = stage[g][0] ^ data_in[g];
        assign stage[g+1] = (stage[g] >> 1) ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    assign crc_out = stage[DATA_W];

endmodule

// File: rtl/crc16_rx_buffer.sv
module crc16_rx_buffer #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);

    localparam int PTR_W  = $clog2(DEPTH + 1);
    localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DATA_W-1:0] mem [0:DEPTH-1];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [ADDR_W-1:0] wr_idx;
    logic [ADDR_W-1:0] rd_idx;
    logic              do_write;

    assign full     = (wr_ptr == PTR_W'(DEPTH));
    assign empty    = (rd_ptr == wr_ptr);
    assign wr_idx   = clr ? '0 : wr_ptr[ADDR_W-1:0];
    assign rd_idx   = rd_ptr[ADDR_W-1:0];
    assign do_write = wr_en && (clr || !full);
    assign rd_data  = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= wr_en ? PTR_W'(1) : '0;
            rd_ptr <= '0;
        end else begin
            if (wr_en && !full) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_en && !empty) rd_ptr <= rd_ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_write) mem[wr_idx] <= wr_data;
    end

    // R6: the write pointer never runs past the buffer depth
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr <= PTR_W'(DEPTH));

    // R5: release never overtakes what was stored
    assert_read_behind_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr <= wr_ptr);

endmodule

// File: rtl/crc16_rx_checker.sv
module crc16_rx_checker
    import crc16_rx_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int CRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_mode,
    input  logic [CRC_W-1:0]  rx_crc,
    output logic              ok_pulse,
    output logic              err_pulse,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_pass
);

    rx_state_e st_q, st_nx;

    logic [CRC_W-1:0]  crc_q, crc_base, crc_nx;
    logic              mode_q, ovf_q;
    logic              acc_first, acc_mid, acc, frame_end;
    logic              mode_eff, ovf_now, ovf_eff, match, pass_now;
    logic              buf_full, buf_empty, buf_rd;
    logic [DATA_W-1:0] buf_rd_data;

    logic              ok_q, err_q, pass_q, out_valid_q;
    logic [DATA_W-1:0] out_data_q;

    assign acc_first = (st_q == ST_IDLE) && in_valid;
    assign acc_mid   = (st_q == ST_RECV) && in_valid;
    assign acc       = acc_first || acc_mid;
    assign frame_end = acc && in_last;
    assign buf_rd    = (st_q == ST_DRAIN);

    assign crc_base  = (st_q == ST_IDLE) ? CRC_PRESET[CRC_W-1:0] : crc_q;
    assign mode_eff  = (st_q == ST_IDLE) ? in_mode : mode_q;
    assign ovf_now   = acc_mid && buf_full;
    assign ovf_eff   = ((st_q == ST_RECV) && ovf_q) || ovf_now;
    assign match     = mode_eff ? (crc_nx == CRC_RESIDUE[CRC_W-1:0])
                                : (~crc_nx == rx_crc);
    assign pass_now  = match && !ovf_eff;

    crc16_byte_step #(
        .DATA_W (DATA_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_POLY_REFL)
    ) u_step (
        .crc_in  (crc_base),
        .data_in (in_data),
        .crc_out (crc_nx)
    );

    crc16_rx_buffer #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (acc_first),
        .wr_en   (acc),
        .wr_data (in_data),
        .rd_en   (buf_rd),
        .rd_data (buf_rd_data),
        .full    (buf_full),
        .empty   (buf_empty)
    );

    // Next-state logic
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) st_nx = in_last ? ST_DRAIN : ST_RECV;
            end
            ST_RECV: begin
                if (in_valid && in_last) st_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (buf_empty) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    // Datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q       <= CRC_PRESET[CRC_W-1:0];
            mode_q      <= 1'b0;
            ovf_q       <= 1'b0;
            ok_q        <= 1'b0;
            err_q       <= 1'b0;
            pass_q      <= 1'b0;
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            if (acc) crc_q <= crc_nx;
            if (acc_first) begin
                mode_q <= in_mode;
                ovf_q  <= 1'b0;
            end else if (ovf_now) begin
                ovf_q  <= 1'b1;
            end
            ok_q  <= frame_end && pass_now;
            err_q <= frame_end && !pass_now;
            if (frame_end) pass_q <= pass_now;
            out_valid_q <= buf_rd && !buf_empty;
            if (buf_rd && !buf_empty) out_data_q <= buf_rd_data;
        end
    end

    assign ok_pulse  = ok_q;
    assign err_pulse = err_q;
    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign out_pass  = pass_q;

    // R4: verdict pulses are exclusive
    assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_pulse && err_pulse));

    // R4: a verdict pulse lasts a single cycle
    assert_flag_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_pulse || err_pulse) |=> !(ok_pulse || err_pulse));

    // R4: a verdict pulse follows an accepted last byte
    assert_flag_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_pulse || err_pulse) |-> $past(frame_end));

    // R5: data release never overlaps the verdict pulse
    assert_release_after_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(ok_pulse || err_pulse));

    // R6: a frame that overflowed ends in an error
    assert_ovf_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RECV) && ovf_q && in_valid && in_last) |=> err_pulse);

    // R7: input during release leaves the CRC register alone
    assert_drain_ignores_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_DRAIN) && in_valid) |=> $stable(crc_q));

endmodule

// File: tb/crc16_rx_checker_tb.sv
`timescale 1ns/1ps
module crc16_rx_checker_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_mode = 1'b0;
    logic [15:0] rx_crc = '0;
    logic        ok_pulse, err_pulse, out_valid, out_pass;
    logic [7:0]  out_data;

    int total = 0;
    int bad = 0;
    logic [7:0] frm [$];

    always #2.5 clk = ~clk;

    crc16_rx_checker #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_mode(in_mode), .rx_crc(rx_crc),
        .ok_pulse(ok_pulse), .err_pulse(err_pulse), .out_valid(out_valid),
        .out_data(out_data), .out_pass(out_pass)
    );

    task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reflected CRC-16 over the frame buffer, per R1 (register value, not inverted)
    function automatic logic [15:0] ref_crc();
        logic [15:0] c = 16'hFFFF;
        foreach (frm[i]) begin
            for (int b = 0; b < 8; b++) begin
                logic fb = c[0] ^ frm[i][b];
                c = (c >> 1) ^ (fb ? 16'hA001 : 16'h0000);
            end
        end
        return c;
    endfunction

    task automatic append_crc();
        logic [15:0] t = ~ref_crc();
        frm.push_back(t[7:0]);
        frm.push_back(t[15:8]);
    endtask

    // Drive the frame in frm, then check verdict and release.
    task automatic run_frame(input bit md, input logic [15:0] rxc, input bit exp_pass,
                             input bit gaps, input bit junk, input string tag);
        int n = frm.size();
        int m = (n > DEPTH) ? DEPTH : n;
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                int g = $urandom_range(0, 2);
                for (int k = 0; k < g; k++) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                    in_mode  = $urandom_range(0, 1);
                end
            end
            @(negedge clk);
            if (i > 0) chk(!ok_pulse && !err_pulse, {tag, " R4 no pulse mid-frame"},
                           {ok_pulse, err_pulse}, 0);
            in_valid = 1'b1;
            in_data  = frm[i];
            in_last  = (i == n - 1);
            in_mode  = (i == 0) ? md : ~md;
            rx_crc   = (i == n - 1) ? rxc : ~rxc;
        end
        @(negedge clk);
        chk(ok_pulse == exp_pass && err_pulse == !exp_pass, {tag, " R4 verdict pulse"},
            {ok_pulse, err_pulse}, {exp_pass, !exp_pass});
        if (junk) begin
            in_valid = 1'b1; in_data = $urandom; in_last = $urandom_range(0, 1);
        end else begin
            in_valid = 1'b0; in_last = 1'b0;
        end
        for (int j = 0; j < m; j++) begin
            @(negedge clk);
            chk(out_valid && out_data == frm[j] && out_pass == exp_pass &&
                !ok_pulse && !err_pulse, {tag, " R5 released byte"},
                {out_valid, out_pass, out_data}, {1'b1, exp_pass, frm[j]});
            if (junk) begin
                in_valid = 1'b1; in_data = $urandom; in_last = $urandom_range(0, 1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(!out_valid && !ok_pulse && !err_pulse, {tag, " R7 quiet after release"},
            {out_valid, ok_pulse, err_pulse}, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [15:0] c;
        logic [7:0] s [9];
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!ok_pulse && !err_pulse && !out_valid && !out_pass, "R8 reset outputs",
            {ok_pulse, err_pulse, out_valid, out_pass}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ok_pulse && !err_pulse && !out_valid && !out_pass, "R8 idle after reset",
            {ok_pulse, err_pulse, out_valid, out_pass}, 0);

        // R1/R2: known string
        s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        frm.delete(); foreach (s[i]) frm.push_back(s[i]);
        c = ~ref_crc();
        chk(c == 16'hB4C8, "R1 bench model known string", c, 16'hB4C8);
        run_frame(1'b0, 16'hB4C8, 1'b1, 1'b0, 1'b0, "R2 known string pass");
        run_frame(1'b0, 16'hB4C9, 1'b0, 1'b0, 1'b0, "R2 known string wrong crc");

        // R3: residue mode
        append_crc();
        c = ref_crc();
        chk(c == 16'hB001, "R3 bench model residue", c, 16'hB001);
        run_frame(1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, "R3 residue pass");
        frm[3] = frm[3] ^ 8'h10;
        run_frame(1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, "R3 residue corrupted");

        // Single-byte frames (R1 preset at first byte)
        frm.delete(); frm.push_back(8'hA5);
        c = ~ref_crc();
        run_frame(1'b0, c, 1'b1, 1'b0, 1'b0, "R1 single byte compare");
        run_frame(1'b1, c, 1'b0, 1'b0, 1'b0, "R3 single byte residue");

        // Exact depth, and overflow (R6)
        frm.delete(); for (int i = 0; i < DEPTH - 2; i++) frm.push_back(8'($urandom));
        append_crc();
        run_frame(1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, "R6 exact depth passes");
        frm.delete(); for (int i = 0; i < DEPTH + 3; i++) frm.push_back(8'($urandom));
        c = ~ref_crc();
        run_frame(1'b0, c, 1'b0, 1'b1, 1'b0, "R6 overflow fails");

        // R7: junk during release, then a clean frame
        frm.delete(); for (int i = 0; i < 5; i++) frm.push_back(8'($urandom));
        c = ~ref_crc();
        run_frame(1'b0, c, 1'b1, 1'b0, 1'b1, "R7 junk in release");
        run_frame(1'b0, c, 1'b1, 1'b0, 1'b0, "R7 frame after junk");

        // Random frames in both modes
        for (int f = 0; f < 80; f++) begin
            bit md = $urandom_range(0, 1);
            bit corrupt = ($urandom_range(0, 9) < 3);
            int n = $urandom_range(1, DEPTH + 2);
            bit exp_p;
            frm.delete();
            for (int i = 0; i < n; i++) frm.push_back(8'($urandom));
            if (md) begin
                append_crc();
                if (corrupt) begin
                    int p = $urandom_range(0, frm.size() - 1);
                    frm[p] = frm[p] ^ (8'h1 << $urandom_range(0, 7));
                end
                exp_p = (ref_crc() == 16'hB001) && (frm.size() <= DEPTH);
                c = 16'h0000;
            end else begin
                c = ~ref_crc();
                if (corrupt) c = c ^ (16'h1 << $urandom_range(0, 15));
                exp_p = (~ref_crc() == c) && (n <= DEPTH);
            end
            run_frame(md, c, exp_p, $urandom_range(0, 1), $urandom_range(0, 1),
                      md ? "R3 random frame" : "R2 random frame");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule